// File: doc/BRIEF.md
# Configuration Revision Select Latch

This block decides which of up to four stored configuration images a configuration memory presents to an FPGA. The revision comes from one of two places. One source is a pair of external select pins. The other is a pair of internally programmed bits. A source-select input chooses between the two.

The chosen revision is not tracked continuously. It is captured once when power-on reset is released, and after that only on a small set of control events:

- chip enable returning high (deselect);
- output-enable/reset falling while chip enable is low;
- the reconfigure pin rising while chip enable is low;
- a reconfiguration command pulse.

The captured revision drives the image start address, which comes from a per-revision table of base addresses. It also drives an error flag that rises when the selected revision holds no image. Revisions may differ in size, for example one large image next to two half-size ones.

Active-low control pins arrive asynchronously and pass through a two-flop synchronizer before edge detection. The reconfiguration command pulse is synchronous to the block clock. The select pins and the programmed bits are treated as quasi-static, and they are sampled only at a capture.

Top module: `rev_select_latch`

## Requirements
- R1: `rev_o` carries the captured revision as a 2-bit code (0=2'b00, 1=2'b01, 2=2'b10, 3=2'b11). `base_addr_o` always equals `BASE_ADDR[rev_o]`.
- R2: At a capture, the revision is taken from `rev_pin_i` when `src_sel_i` is 0 and from `rev_reg_i` when `src_sel_i` is 1.
- R3: While `rst_ni` is low, `rev_o` is 0, `base_addr_o` is `BASE_ADDR[0]` and `absent_err_o` is `!REV_PRESENT[0]`. After `rst_ni` rises, a capture is made and its result appears on the outputs after the second rising clock edge.
- R4: A rising edge of `chip_en_ni` causes a capture.
- R5: A falling edge of `oe_rst_ni` causes a capture only while `chip_en_ni` is low. With `chip_en_ni` high it has no effect.
- R6: A rising edge of `reconf_ni` causes a capture only while `chip_en_ni` is low. With `chip_en_ni` high it has no effect.
- R7: A one-cycle high on `reconf_cmd_i` causes a capture regardless of `chip_en_ni`.
- R8: Between captures, `rev_o`, `base_addr_o` and `absent_err_o` hold steady. Changes on `rev_pin_i`, `rev_reg_i` or `src_sel_i`, a falling edge of `chip_en_ni`, a rising edge of `oe_rst_ni` and a falling edge of `reconf_ni` have no effect on them.
- R9: After a pin event, the outputs show the new capture after the 4th rising clock edge. After a command pulse, they show it after the 2nd rising clock edge.
- R10: `absent_err_o` is high exactly when bit `rev_o` of `REV_PRESENT` is 0.
- R11: Events that coincide cause a single capture of the source-selected revision present at that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| chip_en_ni | input | 1 | Chip enable, active low, asynchronous |
| oe_rst_ni | input | 1 | Output-enable/reset, active low, asynchronous |
| reconf_ni | input | 1 | Reconfigure pin, active low, asynchronous |
| reconf_cmd_i | input | 1 | Reconfiguration command pulse, synchronous |
| src_sel_i | input | 1 | 0: external pins, 1: programmed bits |
| rev_pin_i | input | 2 | External revision select pins |
| rev_reg_i | input | 2 | Programmed revision bits |
| rev_o | output | 2 | Captured revision |
| base_addr_o | output | ADDR_W | Start address of the captured revision |
| absent_err_o | output | 1 | Captured revision holds no image |

## Verification
The assertions check on every cycle that each qualified edge of a synchronized control raises the sample request. They also check that outputs stay steady when no request is present, that a request loads the source-muxed value, and that the address and error flag agree with the captured revision. Only the bench scenarios can show the things that depend on the raw pins. These are the exact latency through the synchronizer, that a disqualified edge (chip enable high) or an opposite edge really leaves the outputs alone, the power-up capture, and the outcome of coincident events. The random phase mixes source switches with every event type.

// File: rtl/rev_sel_pkg.sv
package rev_sel_pkg;
  localparam int unsigned NUM_REV = 4;
  localparam int unsigned REV_W   = $clog2(NUM_REV);
  typedef logic [REV_W-1:0] rev_t;
  // index of each control inside the synchronized vector
  localparam int unsigned CTL_CE  = 0;
  localparam int unsigned CTL_OE  = 1;
  localparam int unsigned CTL_RCF = 2;
  localparam int unsigned CTL_N   = 3;
endpackage

// File: rtl/rsl_sync.sv
module rsl_sync #(
  parameter int unsigned        W       = 1,
  parameter int unsigned        STAGES  = 2,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rsl_event_qual.sv
module rsl_event_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_n_s_i,
  input  logic oe_n_s_i,
  input  logic rcf_n_s_i,
  input  logic cmd_i,
  output logic req_o
);
  logic ce_prev_q, oe_prev_q, rcf_prev_q, started_q, req_q;
  logic ce_rise, oe_fall, rcf_rise, ce_low;

  assign ce_low   = ~ce_n_s_i;
  assign ce_rise  = ce_n_s_i & ~ce_prev_q;
  assign oe_fall  = ~oe_n_s_i & oe_prev_q;
  assign rcf_rise = rcf_n_s_i & ~rcf_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_prev_q  <= 1'b1;
      oe_prev_q  <= 1'b1;
      rcf_prev_q <= 1'b1;
      started_q  <= 1'b0;
      req_q      <= 1'b0;
    end else begin
      ce_prev_q  <= ce_n_s_i;
      oe_prev_q  <= oe_n_s_i;
      rcf_prev_q <= rcf_n_s_i;
      started_q  <= 1'b1;
      // coincident events merge into one request
      req_q      <= ~started_q | ce_rise | cmd_i
                  | (ce_low & (oe_fall | rcf_rise));
    end
  end

  assign req_o = req_q;

  assert_ce_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_n_s_i) |=> req_o);
  assert_oe_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_s_i && $fell(oe_n_s_i)) |=> req_o);
  assert_rcf_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_s_i && $rose(rcf_n_s_i)) |=> req_o);
  assert_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i |=> req_o);
endmodule

// File: rtl/rsl_base_lut.sv
module rsl_base_lut
  import rev_sel_pkg::*;
#(
  parameter int unsigned                     ADDR_W      = 24,
  parameter logic [NUM_REV-1:0][ADDR_W-1:0]  BASE_ADDR   = '0,
  parameter logic [NUM_REV-1:0]              REV_PRESENT = '1
) (
  input  rev_t              rev_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              absent_o
);
  always_comb begin
    base_o   = '0;
    absent_o = 1'b1;
    for (int r = 0; r < NUM_REV; r++) begin
      if (rev_i == rev_t'(r)) begin
        base_o   = BASE_ADDR[r];
        absent_o = ~REV_PRESENT[r];
      end
    end
  end
endmodule

// File: rtl/rsl_capture.sv
module rsl_capture
  import rev_sel_pkg::*;
#(
  parameter int unsigned                     ADDR_W      = 24,
  parameter logic [NUM_REV-1:0][ADDR_W-1:0]  BASE_ADDR   = '0,
  parameter logic [NUM_REV-1:0]              REV_PRESENT = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              src_sel_i,
  input  rev_t              rev_pin_i,
  input  rev_t              rev_reg_i,
  output rev_t              rev_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              err_o
);
  rev_t              sel_rev, rev_q;
  logic [ADDR_W-1:0] lut_base, base_q;
  logic              lut_absent, err_q;

  assign sel_rev = src_sel_i ? rev_reg_i : rev_pin_i;

  rsl_base_lut #(
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR),
    .REV_PRESENT(REV_PRESENT)
  ) i_lut (
    .rev_i   (sel_rev),
    .base_o  (lut_base),
    .absent_o(lut_absent)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rev_q  <= '0;
      base_q <= BASE_ADDR[0];
      err_q  <= ~REV_PRESENT[0];
    end else if (req_i) begin
      rev_q  <= sel_rev;
      base_q <= lut_base;
      err_q  <= lut_absent;
    end
  end

  assign rev_o  = rev_q;
  assign base_o = base_q;
  assign err_o  = err_q;

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(rev_o) && $stable(base_o) && $stable(err_o)));
  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (rev_o == $past(src_sel_i ? rev_reg_i : rev_pin_i)));
endmodule

// File: rtl/rev_select_latch.sv
module rev_select_latch
  import rev_sel_pkg::*;
#(
  parameter int unsigned                     ADDR_W      = 24,
  parameter int unsigned                     SYNC_STAGES = 2,
  parameter logic [NUM_REV-1:0][ADDR_W-1:0]  BASE_ADDR   = {24'h000000, 24'h300000,
                                                            24'h200000, 24'h000000},
  parameter logic [NUM_REV-1:0]              REV_PRESENT = 4'b0111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_en_ni,
  input  logic              oe_rst_ni,
  input  logic              reconf_ni,
  input  logic              reconf_cmd_i,
  input  logic              src_sel_i,
  input  logic [1:0]        rev_pin_i,
  input  logic [1:0]        rev_reg_i,
  output logic [1:0]        rev_o,
  output logic [ADDR_W-1:0] base_addr_o,
  output logic              absent_err_o
);
  logic [CTL_N-1:0] ctl_raw, ctl_s;
  logic             req;
  rev_t             rev_q;

  assign ctl_raw[CTL_CE]  = chip_en_ni;
  assign ctl_raw[CTL_OE]  = oe_rst_ni;
  assign ctl_raw[CTL_RCF] = reconf_ni;

  rsl_sync #(
    .W      (CTL_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL({CTL_N{1'b1}})
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  rsl_event_qual i_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_n_s_i (ctl_s[CTL_CE]),
    .oe_n_s_i (ctl_s[CTL_OE]),
    .rcf_n_s_i(ctl_s[CTL_RCF]),
    .cmd_i    (reconf_cmd_i),
    .req_o    (req)
  );

  rsl_capture #(
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR),
    .REV_PRESENT(REV_PRESENT)
  ) i_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .src_sel_i(src_sel_i),
    .rev_pin_i(rev_pin_i),
    .rev_reg_i(rev_reg_i),
    .rev_o    (rev_q),
    .base_o   (base_addr_o),
    .err_o    (absent_err_o)
  );

  assign rev_o = rev_q;

  assert_base_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_addr_o == BASE_ADDR[rev_o]);
  assert_absent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    absent_err_o == ~REV_PRESENT[rev_o]);
endmodule

// File: tb/test_rev_select_latch.sv
module test_rev_select_latch;
  localparam int unsigned ADDR_W = 24;
  localparam logic [3:0][ADDR_W-1:0] BASE = {24'h000000, 24'h300000, 24'h200000, 24'h000000};
  localparam logic [3:0] PRES = 4'b0111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, rcf_n = 1'b1, cmd = 1'b0, src = 1'b0;
  logic [1:0] pins = 2'b10, bits = 2'b01;
  logic [1:0] rev;
  logic [ADDR_W-1:0] base;
  logic err;
  logic [1:0] exp_rev = 2'b00;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rev_select_latch #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .REV_PRESENT(PRES)) i_rev_select_latch (
    .clk_i(clk), .rst_ni(rst_n), .chip_en_ni(ce_n), .oe_rst_ni(oe_n), .reconf_ni(rcf_n),
    .reconf_cmd_i(cmd), .src_sel_i(src), .rev_pin_i(pins), .rev_reg_i(bits),
    .rev_o(rev), .base_addr_o(base), .absent_err_o(err));

  function automatic logic [1:0] model_sel(logic s, logic [1:0] p, logic [1:0] b);
    return s ? b : p;
  endfunction

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req);
    checks++;
    if (rev !== exp_rev || base !== BASE[exp_rev] || err !== ~PRES[exp_rev]) begin
      errors++;
      $display("FAIL %s: rev=%0d base=%h err=%0b expected rev=%0d base=%h err=%0b",
               req, rev, base, err, exp_rev, BASE[exp_rev], ~PRES[exp_rev]);
    end
  endtask

  task automatic set_ce(logic lvl);
    if (ce_n !== lvl) begin
      ce_n = lvl;
      if (lvl) exp_rev = model_sel(src, pins, bits);
      settle(6);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    settle(3);
    check("R3 reset state");
    rst_n = 1'b1;
    exp_rev = model_sel(src, pins, bits);
    settle(2);
    check("R3 power-up capture pins=2");

    pins = 2'b01; settle(6);
    check("R8 pin change ignored");
    ce_n = 1'b0; settle(6);
    check("R8 ce falling ignored");
    ce_n = 1'b1; exp_rev = 2'b01; settle(4);
    check("R4 R9 ce rising capture");

    ce_n = 1'b0; settle(6);
    src = 1'b1; bits = 2'b11;
    oe_n = 1'b0; exp_rev = 2'b11; settle(6);
    check("R5 R2 R10 oe fall ce low, rev3 absent");
    oe_n = 1'b1; settle(6);
    check("R8 oe rising ignored");

    ce_n = 1'b1; exp_rev = 2'b11; settle(6);
    src = 1'b0; pins = 2'b00;
    oe_n = 1'b0; settle(6);
    check("R5 oe fall with ce high ignored");
    oe_n = 1'b1; settle(6);
    rcf_n = 1'b0; settle(6);
    check("R8 reconf falling ignored");
    rcf_n = 1'b1; settle(6);
    check("R6 reconf rise with ce high ignored");

    ce_n = 1'b0; settle(6);
    rcf_n = 1'b0; settle(6);
    rcf_n = 1'b1; exp_rev = 2'b00; settle(6);
    check("R6 reconf rise with ce low");

    ce_n = 1'b1; exp_rev = 2'b00; settle(6);
    pins = 2'b10;
    cmd = 1'b1; @(negedge clk); cmd = 1'b0;
    exp_rev = 2'b10;
    settle(1);
    check("R7 R9 command pulse");

    ce_n = 1'b0; settle(6);
    src = 1'b1; bits = 2'b01;
    ce_n = 1'b1; cmd = 1'b1; @(negedge clk); cmd = 1'b0;
    exp_rev = 2'b01; settle(6);
    check("R11 coincident events");

    for (int it = 0; it < 60; it++) begin
      logic [2:0] act;
      set_ce(1'($urandom_range(0, 1)));
      src  = 1'($urandom_range(0, 1));
      pins = 2'($urandom_range(0, 3));
      bits = 2'($urandom_range(0, 3));
      act  = 3'($urandom_range(0, 4));
      case (act)
        3'd0: settle(6);
        3'd1: begin
          set_ce(1'b0);
          ce_n = 1'b1; exp_rev = model_sel(src, pins, bits); settle(6);
        end
        3'd2: begin
          oe_n = 1'b0;
          if (!ce_n) exp_rev = model_sel(src, pins, bits);
          settle(6); oe_n = 1'b1; settle(6);
        end
        3'd3: begin
          rcf_n = 1'b0; settle(6);
          rcf_n = 1'b1;
          if (!ce_n) exp_rev = model_sel(src, pins, bits);
          settle(6);
        end
        default: begin
          cmd = 1'b1; @(negedge clk); cmd = 1'b0;
          exp_rev = model_sel(src, pins, bits); settle(6);
        end
      endcase
      case (act)
        3'd0:    check("R8 random hold");
        3'd1:    check("R4 random ce rise");
        3'd2:    check("R5 random oe fall");
        3'd3:    check("R6 random reconf rise");
        default: check("R7 random command");
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule